// File: doc/BRIEF.md
# Paged Serial Memory Target

This block is a two-wire serial bus target that presents a small byte-wide memory behind one 7-bit bus address. A controller first writes a two-byte word pointer, most significant byte first. It then either streams data bytes to be stored, or issues a repeated START with the read direction and clocks bytes back out. During a read the pointer advances after every byte.

Incoming data bytes are gathered in a one-page staging buffer. Within a page the pointer offset wraps and the page number stays fixed. The staged bytes reach the memory array only when a STOP ends the message. A repeated START throws them away.

After a committing STOP, the target emulates a slow programming cycle. For a parameterised number of clocks it refuses to acknowledge its own address. Both bus lines are oversampled by the system clock, and SDA is driven open-drain through an output enable.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the target releases SDA (`sda_oe` = 0) and every memory byte reads as 0x00.
- R2: The first byte after START is {7-bit address, direction}, where direction 0 means write and 1 means read. The target pulls SDA low on the ninth clock only when the address equals `DEV_ADDR`. For any other address it leaves SDA released for the rest of the message.
- R3: In a write message, the two bytes after the address byte set the pointer (high byte first, low byte second; only the low log2(`MEM_BYTES`) bits are kept). Later bytes are stored at consecutive addresses, and every received byte is acknowledged on its ninth clock.
- R4: Data bytes of one write message stay in one `PAGE_BYTES` page: the offset wraps from the page end to the page start, and the upper pointer bits never change.
- R5: Staged write data is stored only when a STOP ends the message. A repeated START discards it, leaves the memory unchanged and starts no busy period.
- R6: For `BUSY_CYCLES` clocks after a STOP that stored data, the target does not acknowledge its own address. After that period it acknowledges the address again.
- R7: A read message returns the byte at the pointer, and the pointer increments after each byte sent. This covers a read after a repeated START that follows a pointer write.
- R8: Sequential reads wrap from address `MEM_BYTES`-1 to address 0.
- R9: When the controller answers a read byte with NACK (SDA high on the ninth clock), the target stops driving and keeps SDA released until the next START or STOP.
- R10: `sda_oe` changes only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest states to reach from the pins are the busy window and a staged write that is abandoned. To reach the busy window, the stimulus sends a new address byte right after a committing STOP, well inside the window. It then retries after the window has run out. The abandoned write is made by a repeated START that follows a data byte. The bench then checks through ordinary reads and address probes that no byte changed and that the address is still acknowledged. Page wrap is made visible by writing past the end of a page and reading back both the page start and the bytes just past the page end.

// File: rtl/smt_pkg.sv
package smt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_RACK,
      ST_TX,
      ST_TACK,
      ST_WAIT
   } smt_state_e;
endpackage

// File: rtl/smt_line_sync.sv
module smt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smt_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_p  <= scl_sh[STAGES-1];
         sda_p  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smt_store.sv
module smt_store #(
   parameter int MEM_BYTES  = 256,
   parameter int PAGE_BYTES = 32,
   localparam int AW = $clog2(MEM_BYTES),
   localparam int PW = $clog2(PAGE_BYTES),
   localparam int GW = AW - PW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  logic [GW-1:0]           page_sel,
   input  logic [PAGE_BYTES*8-1:0] stage_data,
   input  logic [PAGE_BYTES-1:0]   stage_mask,
   input  logic [AW-1:0]           rd_addr,
   output logic [7:0]              rd_data
);
   logic [7:0] cells [MEM_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < MEM_BYTES; e++) cells[e] <= 8'h00;
      end else if (commit) begin
         for (int e = 0; e < MEM_BYTES; e++) begin
            if (stage_mask[e % PAGE_BYTES] && page_sel == GW'(e / PAGE_BYTES))
               cells[e] <= stage_data[(e % PAGE_BYTES)*8 +: 8];
         end
      end
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/smt_busy_timer.sv
module smt_busy_timer #(
   parameter int BUSY_CYCLES = 5000,
   localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("smt_busy_timer: BUSY_CYCLES must be positive");
   end

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (start)           remain <= CW'(BUSY_CYCLES);
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   // R6
   busy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= CW'(BUSY_CYCLES));
   // R5
   busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         MEM_BYTES   = 256,
   parameter int         PAGE_BYTES  = 32,
   parameter int         BUSY_CYCLES = 5000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   import smt_pkg::*;

   localparam int AW = $clog2(MEM_BYTES);
   localparam int PW = $clog2(PAGE_BYTES);
   localparam int GW = AW - PW;

   if ((1 << AW) != MEM_BYTES || (1 << PW) != PAGE_BYTES) begin : g_bad_pow2
      $error("serial_mem_target: sizes must be powers of two");
   end
   if (AW > 16 || MEM_BYTES < 2*PAGE_BYTES || PAGE_BYTES < 2) begin : g_bad_size
      $error("serial_mem_target: memory must hold two pages and fit a 16-bit pointer");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, commit;
   logic [7:0] rd_data;

   smt_state_e             state;
   logic [3:0]             bit_cnt;
   logic [7:0]             rx_sh, tx_sh, addr_hi;
   logic [1:0]             byte_idx;
   logic                   rw, m_ack;
   logic [AW-1:0]          ptr;
   logic [PAGE_BYTES*8-1:0] pbuf;
   logic [PAGE_BYTES-1:0]  pmask;
   logic [15:0]            full_addr;
   logic                   wr_phase;

   smt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   smt_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n), .commit(commit), .page_sel(ptr[AW-1:PW]),
      .stage_data(pbuf), .stage_mask(pmask), .rd_addr(ptr), .rd_data(rd_data));

   smt_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .start(commit), .busy(busy));

   assign commit    = stop_det && (pmask != '0);
   assign full_addr = {addr_hi, rx_sh};
   assign wr_phase  = (state == ST_RX || state == ST_RACK) && byte_idx == 2'd2 && !rw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         addr_hi  <= '0;
         byte_idx <= '0;
         rw       <= 1'b0;
         m_ack    <= 1'b0;
         ptr      <= '0;
         pbuf     <= '0;
         pmask    <= '0;
         sda_oe   <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
         pmask  <= '0;
      end else if (start_det) begin
         state   <= ST_ADDR;
         bit_cnt <= '0;
         sda_oe  <= 1'b0;
         pmask   <= '0;
      end else begin
         case (state)
            ST_ADDR, ST_RX: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall && bit_cnt == 4'd8) begin
                  if (state == ST_ADDR) begin
                     if (rx_sh[7:1] == DEV_ADDR && !busy) begin
                        sda_oe   <= 1'b1;
                        rw       <= rx_sh[0];
                        byte_idx <= 2'd0;
                        state    <= ST_AACK;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end else begin
                     sda_oe <= 1'b1;
                     state  <= ST_RACK;
                     case (byte_idx)
                        2'd0: begin
                           addr_hi  <= rx_sh;
                           byte_idx <= 2'd1;
                        end
                        2'd1: begin
                           ptr      <= full_addr[AW-1:0];
                           byte_idx <= 2'd2;
                        end
                        default: begin
                           pbuf[ptr[PW-1:0]*8 +: 8] <= rx_sh;
                           pmask[ptr[PW-1:0]]       <= 1'b1;
                           ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                        end
                     endcase
                  end
               end
            end
            ST_AACK, ST_RACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (state == ST_AACK && rw) begin
                     tx_sh  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     state  <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall) begin
                  if (bit_cnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     ptr    <= ptr + 1'b1;
                     state  <= ST_TACK;
                  end else begin
                     tx_sh  <= {tx_sh[6:0], 1'b0};
                     sda_oe <= ~tx_sh[6];
                  end
               end
            end
            ST_TACK: begin
               if (scl_rise) begin
                  m_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (m_ack) begin
                     tx_sh   <= rd_data;
                     sda_oe  <= ~rd_data[7];
                     bit_cnt <= '0;
                     state   <= ST_TX;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R10
   oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_s);
   // R6
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_AACK) |-> !busy);
   // R4
   page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_phase && $past(wr_phase)) |-> ptr[AW-1:PW] == $past(ptr[AW-1:PW]));
   // R5
   stage_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start_det) |-> pmask == '0);
   // R9
   wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && $past(state) == ST_WAIT) |-> !sda_oe);
endmodule

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;
   localparam int Q    = 8;
   localparam int BUSY = 400;
   localparam logic [7:0] WA = 8'hA0;
   localparam logic [7:0] RA = 8'hA1;
   // vector: {pointer[15:0], seed[7:0], length[5:0]}
   localparam logic [29:0] VEC [0:5] = '{
      {16'h0003, 8'h11, 6'd4},
      {16'h0020, 8'h3C, 6'd8},
      {16'h00A5, 8'hF0, 6'd3},
      {16'h0090, 8'h5A, 6'd2},
      {16'h00C0, 8'h01, 6'd32},
      {16'h0011, 8'h80, 6'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   wire  sda_line = m_sda & ~sda_oe;

   int nchk = 0;
   int nfail = 0;
   int r10_bad = 0;
   bit done = 1'b0;
   logic oe_prev = 1'b0;
   logic [7:0] model [256];

   always #5 clk = ~clk;

   serial_mem_target #(.DEV_ADDR(7'h50), .MEM_BYTES(256), .PAGE_BYTES(32),
                       .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe));

   // R10 monitor: output enable may only move while the controller holds SCL low
   always @(negedge clk) begin
      if (rst_n && m_scl && sda_oe !== oe_prev) r10_bad++;
      oe_prev <= sda_oe;
   end

   task automatic wq(input int n);
      repeat (n*Q) @(negedge clk);
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic b_start();
      m_sda = 1'b0; wq(1); m_scl = 1'b0; wq(1);
   endtask
   task automatic b_rstart();
      m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(1); m_sda = 1'b0; wq(1); m_scl = 1'b0; wq(1);
   endtask
   task automatic b_stop();
      m_sda = 1'b0; wq(1); m_scl = 1'b1; wq(1); m_sda = 1'b1; wq(1);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(1); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(1);
      end
      m_sda = 1'b1; wq(1); m_scl = 1'b1; wq(1); ack = ~sda_line; wq(1); m_scl = 1'b0; wq(1);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(1); m_scl = 1'b1; wq(1); d[i] = sda_line; wq(1); m_scl = 1'b0;
      end
      m_sda = ~give_ack; wq(1); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(1); m_sda = 1'b1;
   endtask

   task automatic write_msg(input logic [7:0] a, input int n, input logic [7:0] seed);
      logic ack;
      b_start();
      send_byte(WA, ack); chk({7'd0, ack}, 8'd1, "R2 address ack on write");
      send_byte(8'h00, ack); chk({7'd0, ack}, 8'd1, "R3 pointer high ack");
      send_byte(a, ack); chk({7'd0, ack}, 8'd1, "R3 pointer low ack");
      for (int i = 0; i < n; i++) begin
         send_byte(seed + 8'(i), ack);
         chk({7'd0, ack}, 8'd1, "R3 data ack");
      end
      b_stop();
      for (int i = 0; i < n; i++)
         model[(int'(a) & 8'hE0) | ((int'(a) + i) & 31)] = seed + 8'(i);
      repeat (BUSY + 40) @(negedge clk);
   endtask

   task automatic read_msg(input logic [7:0] a, input int n, input string tag);
      logic ack;
      logic [7:0] d;
      b_start();
      send_byte(WA, ack); chk({7'd0, ack}, 8'd1, "R2 address ack before read");
      send_byte(8'h00, ack);
      send_byte(a, ack);
      b_rstart();
      send_byte(RA, ack); chk({7'd0, ack}, 8'd1, "R7 read address ack");
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n-1, d);
         chk(d, model[(int'(a) + i) & 255], tag);
      end
      b_stop();
   endtask

   initial begin
      logic ack;
      logic [7:0] d;
      for (int i = 0; i < 256; i++) model[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk({7'd0, sda_oe}, 8'd0, "R1 sda released after reset");
      read_msg(8'h10, 2, "R1 memory clear after reset");

      // R2 foreign address stays silent for the whole message
      b_start();
      send_byte(8'hB0, ack); chk({7'd0, ack}, 8'd0, "R2 foreign address nack");
      send_byte(8'h00, ack); chk({7'd0, ack}, 8'd0, "R2 silent after foreign address");
      b_stop();

      // R3 R7 vector table: write a run, then read it back
      for (int v = 0; v < 6; v++) begin
         logic [29:0] e;
         e = VEC[v];
         write_msg(e[21:14], int'(e[5:0]), e[13:6]);
         read_msg(e[21:14], int'(e[5:0]), "R3 R7 readback");
      end

      // R4 page wrap: 4 bytes from 0x5E land at 5E,5F,40,41
      write_msg(8'h5E, 4, 8'hB0);
      chk(model[8'h40], 8'hB2, "R4 model wrap");
      read_msg(8'h5E, 4, "R4 bytes past page end untouched");
      read_msg(8'h40, 2, "R4 wrapped bytes at page start");

      // R5 repeated START drops staged data
      b_start();
      send_byte(WA, ack); send_byte(8'h00, ack); send_byte(8'h80, ack);
      send_byte(8'h55, ack); chk({7'd0, ack}, 8'd1, "R5 staged byte ack");
      b_rstart();
      send_byte(RA, ack); chk({7'd0, ack}, 8'd1, "R5 read after abandoned write");
      recv_byte(1'b0, d); chk(d, model[8'h81], "R5 pointer advanced inside page");
      b_stop();
      b_start();
      send_byte(WA, ack); chk({7'd0, ack}, 8'd1, "R5 no busy after abandoned write");
      b_stop();
      read_msg(8'h80, 1, "R5 memory unchanged");

      // R6 busy window
      b_start();
      send_byte(WA, ack); send_byte(8'h00, ack); send_byte(8'h33, ack);
      send_byte(8'hC7, ack);
      b_stop();
      model[8'h33] = 8'hC7;
      b_start();
      send_byte(WA, ack); chk({7'd0, ack}, 8'd0, "R6 nack during busy");
      b_stop();
      repeat (BUSY + 40) @(negedge clk);
      b_start();
      send_byte(WA, ack); chk({7'd0, ack}, 8'd1, "R6 ack after busy");
      b_stop();
      read_msg(8'h33, 1, "R6 committed byte");

      // R8 read wrap top to zero
      write_msg(8'hFF, 1, 8'h77);
      read_msg(8'hFF, 2, "R8 wrap to address 0");

      // R9 controller NACK ends the read
      b_start();
      send_byte(WA, ack); send_byte(8'h00, ack); send_byte(8'h03, ack);
      b_rstart();
      send_byte(RA, ack);
      recv_byte(1'b0, d); chk(d, model[8'h03], "R9 byte before nack");
      recv_byte(1'b0, d); chk(d, 8'hFF, "R9 line released after nack");
      b_stop();

      chk(8'(r10_bad), 8'd0, "R10 sda_oe moved while SCL high");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule